// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the device from power-up to operation. After reset it holds the clock enable low, raises it, waits a stabilization interval counted in clock cycles, and then issues, with the spacing each step needs, one precharge-all, a parameterized number of auto-refresh commands and a single load-mode-register command. The mode word it loads is built at elaboration from the chosen burst length and CAS latency, with sequential bursts, standard operation and single-location writes.

Once the mode command has settled, the block reports that initialization is done and starts a periodic refresh timer. Its reload value is computed from the refresh period in milliseconds, the clock frequency in kHz and the row count, less a fixed margin of 20 cycles. Each time the timer expires it pulses a refresh request for the memory controller. After initialization the block also accepts requests to move the device into self-refresh, power-down or back to normal operation. It issues the matching command and holds the clock enable level that mode requires.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, cke is low, the command pins are deselected ({cs_n,ras_n,cas_n,we_n} = 1111), and init_done and refresh_req are both low.
- R2: One cycle after reset is released, cke goes high and NOP (0111) is driven for STABLE_CYC cycles. Precharge-all (0010) with addr[10] = 1 follows, and the next command comes TRP_CYC cycles after it. During initialization the only commands other than NOP are precharge-all, the auto-refreshes and the mode load.
- R3: Exactly AREF_COUNT auto-refresh commands (0001) are issued during initialization, each TRC_CYC cycles after the one before it. The first comes TRP_CYC cycles after precharge-all.
- R4: The mode load (0000) comes TRC_CYC cycles after the last auto-refresh and is issued once, with ba = 0. Its addr carries the burst code in bits [2:0] (length 1 → 0, 2 → 1, 4 → 2, 8 → 4), bit 3 = 0 for sequential bursts, the CAS latency value in bits [6:4], bit 9 = 1 for single-location writes, and zero in all other bits.
- R5: init_done rises TMRD_CYC cycles after the mode load and stays high until the next reset. No command other than NOP is driven in between.
- R6: The refresh reload value is REFRESH_MS*CLK_KHZ/ROW_COUNT − 20 (683 for 64 ms, 90000 kHz and 8192 rows). refresh_req pulses for one cycle, first RELOAD cycles after init_done rises and then every RELOAD+1 cycles.
- R7: lp_req has no effect before init_done is high.
- R8: lp_req with lp_mode = 1 (self-refresh) issues one auto-refresh command (0001) with cke low and addr = 0, ba = 0. After that, NOP is driven with cke held low.
- R9: lp_req with lp_mode = 2 (power-down) drives cke low with NOP.
- R10: lp_req with lp_mode = 0 (normal) drives cke high with NOP.
- R11: refresh_req stays low while the device is in self-refresh or power-down. The refresh timer keeps counting, so pulses resume on the original schedule once normal mode is restored.
- R12: lp_req with lp_mode = 3 (reserved) is ignored: the mode and the pins stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | Request a mode change to lp_mode |
| lp_mode | input | 2 | Target mode: 0 normal, 1 self-refresh, 2 power-down, 3 reserved |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus, carries A10 and the mode word |
| init_done | output | 1 | Initialization complete |
| refresh_req | output | 1 | One-cycle auto-refresh request |

## Verification
The hardest thing to reach from the ports is a refresh-timer expiry that lands while the device sits in self-refresh. The request must then be suppressed, and the timer must still stay in phase so that the next pulse after returning to normal mode falls exactly RELOAD+1 cycles later. The stimulus uses the real 683-cycle reload and counts cycles from the release of reset. It enters self-refresh just before a known expiry, moves through power-down and a reserved request, returns to normal, and samples refresh_req on the exact predicted cycles. A mode request is also held asserted through the early initialization steps to show that it is ignored there.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR   = 4'b0000,
      CMD_AREF  = 4'b0001,
      CMD_PALL  = 4'b0010,
      CMD_NOP   = 4'b0111,
      CMD_DESEL = 4'b1111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_PWR, ST_WAIT, ST_PALL, ST_AREF, ST_LMR, ST_RUN, ST_MCMD
   } boot_st_e;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'd0,
      PM_SELF   = 2'd1,
      PM_PDOWN  = 2'd2,
      PM_RSVD   = 2'd3
   } pwr_mode_e;

   function automatic logic [9:0] mode_word(input int burst, input int cas);
      logic [9:0] w;
      w = 10'h200;                       // single-location write bursts
      case (burst)
         2:       w[2:0] = 3'd1;
         4:       w[2:0] = 3'd2;
         8:       w[2:0] = 3'd4;
         default: w[2:0] = 3'd0;
      endcase
      w[6:4] = 3'(cas);                  // bit 3 stays 0: sequential
      return w;
   endfunction

   function automatic int refresh_reload(input int ms, input int khz, input int rows);
      return (ms * khz) / rows - 20;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
   import sdram_boot_pkg::*;
#(
   parameter int STABLE_CYC = 20,
   parameter int TRP_CYC    = 2,
   parameter int TRC_CYC    = 7,
   parameter int TMRD_CYC   = 2,
   parameter int AREF_COUNT = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lp_req,
   input  logic [1:0] lp_mode,
   output boot_st_e  state,
   output pwr_mode_e pmode
);
   localparam int CNT_MAX = max4(STABLE_CYC + 1, TRP_CYC, TRC_CYC, TMRD_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int ACNT_W  = $clog2(AREF_COUNT + 1);

   logic [CNT_W-1:0]  wait_cnt;
   logic [CNT_W-1:0]  gap;
   logic [ACNT_W-1:0] aref_n;
   boot_st_e          ret_st;
   boot_st_e          nxt_st;
   logic              lp_take;

   // spacing from this command to the next one, in cycles
   always_comb begin
      gap    = CNT_W'(1);
      nxt_st = ST_RUN;
      case (state)
         ST_PWR:  begin gap = CNT_W'(STABLE_CYC + 1); nxt_st = ST_PALL; end
         ST_PALL: begin gap = CNT_W'(TRP_CYC);        nxt_st = ST_AREF; end
         ST_AREF: begin
            gap    = CNT_W'(TRC_CYC);
            nxt_st = (aref_n == ACNT_W'(AREF_COUNT - 1)) ? ST_LMR : ST_AREF;
         end
         ST_LMR:  begin gap = CNT_W'(TMRD_CYC);       nxt_st = ST_RUN; end
         default: ;
      endcase
   end

   assign lp_take = lp_req && (lp_mode != PM_RSVD) && (lp_mode != pmode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_PWR;
         ret_st   <= ST_PWR;
         wait_cnt <= '0;
         aref_n   <= '0;
         pmode    <= PM_NORMAL;
      end else begin
         case (state)
            ST_PWR, ST_PALL, ST_AREF, ST_LMR: begin
               if (state == ST_AREF) aref_n <= aref_n + 1'b1;
               if (gap == CNT_W'(1)) begin
                  state <= nxt_st;
               end else begin
                  wait_cnt <= gap - CNT_W'(2);
                  ret_st   <= nxt_st;
                  state    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (wait_cnt == '0) state <= ret_st;
               else                wait_cnt <= wait_cnt - 1'b1;
            end
            ST_RUN: begin
               if (lp_take) begin
                  pmode <= pwr_mode_e'(lp_mode);
                  state <= ST_MCMD;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
   import sdram_boot_pkg::*;
#(
   parameter int               ADDR_W = 13,
   parameter int               BA_W   = 2,
   parameter logic [ADDR_W-1:0] MODE   = '0
) (
   input  boot_st_e          state,
   input  pwr_mode_e         pmode,
   output logic              cke,
   output sd_cmd_e           cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   always_comb begin
      cke  = 1'b1;
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      case (state)
         ST_PWR:  begin cke = 1'b0; cmd = CMD_DESEL; end
         ST_PALL: begin cmd = CMD_PALL; addr[10] = 1'b1; end
         ST_AREF: cmd = CMD_AREF;
         ST_LMR:  begin cmd = CMD_LMR; addr = MODE; end
         ST_RUN:  cke = (pmode == PM_NORMAL);
         ST_MCMD: begin
            case (pmode)
               PM_SELF:  begin cke = 1'b0; cmd = CMD_AREF; end
               PM_PDOWN: cke = 1'b0;
               default:  cke = 1'b1;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sdram_refresh_tmr.sv
module sdram_refresh_tmr #(
   parameter int RELOAD = 683
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic allow,
   output logic req
);
   localparam int RF_W = $clog2(RELOAD + 1);

   logic [RF_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= RF_W'(RELOAD);
      else if (!run)           cnt <= RF_W'(RELOAD);
      else if (cnt == '0)      cnt <= RF_W'(RELOAD);
      else                     cnt <= cnt - 1'b1;
   end

   assign req = run && allow && (cnt == '0);
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int CLK_KHZ    = 90000,
   parameter int STARTUP_MS = 100,
   parameter int STABLE_CYC = STARTUP_MS * CLK_KHZ,
   parameter int TRP_CYC    = 2,
   parameter int TRC_CYC    = 7,
   parameter int TMRD_CYC   = 2,
   parameter int AREF_COUNT = 8,
   parameter int BURST_LEN  = 1,
   parameter int CAS_LAT    = 2,
   parameter int REFRESH_MS = 64,
   parameter int ROW_COUNT  = 8192,
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_req,
   input  logic [1:0]        lp_mode,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done,
   output logic              refresh_req
);
   localparam int                RELOAD    = refresh_reload(REFRESH_MS, CLK_KHZ, ROW_COUNT);
   localparam logic [ADDR_W-1:0] MODE_WORD = {{(ADDR_W - 10){1'b0}}, mode_word(BURST_LEN, CAS_LAT)};

   // elaboration-time parameter checks
   if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_burst
      $error("sdram_boot_seq: BURST_LEN must be 1, 2, 4 or 8");
   end
   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cas
      $error("sdram_boot_seq: CAS_LAT must be 2 or 3");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("sdram_boot_seq: ADDR_W must reach A10");
   end
   if (TRP_CYC < 1 || TRC_CYC < 1 || TMRD_CYC < 2 || STABLE_CYC < 1 || AREF_COUNT < 1) begin : g_bad_timing
      $error("sdram_boot_seq: timing parameters out of range");
   end
   if (RELOAD < 1) begin : g_bad_reload
      $error("sdram_boot_seq: refresh reload must be positive");
   end

   boot_st_e  state;
   pwr_mode_e pmode;
   sd_cmd_e   cmd;

   sdram_boot_fsm #(
      .STABLE_CYC (STABLE_CYC),
      .TRP_CYC    (TRP_CYC),
      .TRC_CYC    (TRC_CYC),
      .TMRD_CYC   (TMRD_CYC),
      .AREF_COUNT (AREF_COUNT)
   ) i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .lp_req  (lp_req),
      .lp_mode (lp_mode),
      .state   (state),
      .pmode   (pmode)
   );

   sdram_cmd_drive #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W),
      .MODE   (MODE_WORD)
   ) i_drive (
      .state (state),
      .pmode (pmode),
      .cke   (cke),
      .cmd   (cmd),
      .ba    (ba),
      .addr  (addr)
   );

   assign init_done = (state == ST_RUN) || (state == ST_MCMD);

   sdram_refresh_tmr #(
      .RELOAD (RELOAD)
   ) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (init_done),
      .allow (pmode == PM_NORMAL),
      .req   (refresh_req)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done,
   input logic              refresh_req
);
   logic [3:0] pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done) else $error("init_done dropped");             // R5

   AST_LMR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0000) |=> (pins == 4'b0111)) else $error("no gap after mode load"); // R5

   AST_LMR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0000) |-> !init_done) else $error("mode load after init"); // R4

   AST_PALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0010) |-> addr[10]) else $error("precharge without A10");  // R2

   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> (init_done && cke)) else $error("refresh outside normal"); // R11

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |=> !refresh_req) else $error("refresh request too long"); // R6

endmodule

bind sdram_boot_seq sdram_boot_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .addr        (addr),
   .init_done   (init_done),
   .refresh_req (refresh_req)
);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 13;
   localparam int BA_W       = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lp_req = 1'b0;
   logic [1:0]        lp_mode = 2'd0;
   logic              cke, cs_n, ras_n, cas_n, we_n;
   logic [BA_W-1:0]   ba;
   logic [ADDR_W-1:0] addr;
   logic              init_done, refresh_req;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   int aref_seen = 0;
   int cmd_seen  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_boot_seq #(
      .STABLE_CYC (20),
      .TRP_CYC    (3),
      .TRC_CYC    (5),
      .TMRD_CYC   (2),
      .AREF_COUNT (3),
      .BURST_LEN  (4),
      .CAS_LAT    (3),
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W)
   ) i_sdram_boot_seq (
      .clk, .rst_n, .lp_req, .lp_mode, .cke, .cs_n, .ras_n, .cas_n, .we_n,
      .ba, .addr, .init_done, .refresh_req
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // commands seen during initialization
   always @(negedge clk) begin
      if (rst_n && !init_done && cke && !cs_n) begin
         if ({ras_n, cas_n, we_n} == 3'b001) aref_seen++;
         if ({ras_n, cas_n, we_n} != 3'b111) cmd_seen++;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic wait_cyc(input int k);
      while (cyc < k) @(negedge clk);
   endtask

   function automatic int pins();
      return {cke, cs_n, ras_n, cas_n, we_n};
   endfunction

   // init command table: cycle, {cke,cs,ras,cas,we}, addr
   localparam int   N_EV = 5;
   localparam int   EV_CYC  [N_EV] = '{21, 24, 29, 34, 39};
   localparam int   EV_PINS [N_EV] = '{5'b10010, 5'b10001, 5'b10001, 5'b10001, 5'b10000};
   localparam int   EV_ADDR [N_EV] = '{13'h400, 0, 0, 0, 13'h232};

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, with a mode request pending (R7)
      lp_req  = 1'b1;
      lp_mode = 2'd2;
      check("R1", "cke", cke, 0);
      check("R1", "pins", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
      check("R1", "init_done", init_done, 0);
      check("R1", "refresh_req", refresh_req, 0);
      rst_n = 1'b1;

      wait_cyc(1);
      check("R2", "clock enable nop", pins(), 5'b10111);
      wait_cyc(10);
      check("R7", "cke during early request", cke, 1);

      for (int i = 0; i < N_EV; i++) begin
         wait_cyc(EV_CYC[i]);
         check(i == 0 ? "R2" : (i == 4 ? "R4" : "R3"), "command", pins(), EV_PINS[i]);
         check(i == 0 ? "R2" : (i == 4 ? "R4" : "R3"), "addr", addr, EV_ADDR[i]);
         if (i == 4) check("R4", "ba", ba, 0);
         if (i == 2) lp_req = 1'b0;
      end

      wait_cyc(40);
      check("R5", "init_done before tmrd", init_done, 0);
      wait_cyc(41);
      check("R5", "init_done after tmrd", init_done, 1);
      check("R7", "normal mode after init", pins(), 5'b10111);
      check("R3", "auto-refresh count", aref_seen, 3);
      check("R2", "init command count", cmd_seen, 5);

      // R6 refresh schedule: reload 683
      wait_cyc(723);
      check("R6", "refresh early", refresh_req, 0);
      wait_cyc(724);
      check("R6", "first refresh", refresh_req, 1);
      wait_cyc(725);
      check("R6", "refresh pulse width", refresh_req, 0);
      wait_cyc(1408);
      check("R6", "second refresh", refresh_req, 1);

      // R8 self-refresh
      wait_cyc(1500);
      lp_req = 1'b1; lp_mode = 2'd1;
      wait_cyc(1501);
      check("R8", "self-refresh command", pins(), 5'b00001);
      check("R8", "self-refresh addr", addr, 0);
      lp_req = 1'b0;
      wait_cyc(1502);
      check("R8", "self-refresh hold", pins(), 5'b00111);
      wait_cyc(2092);
      check("R11", "refresh suppressed in self-refresh", refresh_req, 0);

      // R9 power-down
      wait_cyc(2100);
      lp_req = 1'b1; lp_mode = 2'd2;
      wait_cyc(2101);
      check("R9", "power-down", pins(), 5'b00111);
      lp_req = 1'b0;

      // R12 reserved mode
      wait_cyc(2200);
      lp_req = 1'b1; lp_mode = 2'd3;
      wait_cyc(2203);
      check("R12", "reserved mode ignored", pins(), 5'b00111);
      lp_req = 1'b0;

      // R10 back to normal
      wait_cyc(2300);
      lp_req = 1'b1; lp_mode = 2'd0;
      wait_cyc(2301);
      check("R10", "normal mode", pins(), 5'b10111);
      lp_req = 1'b0;
      wait_cyc(2775);
      check("R11", "no refresh off schedule", refresh_req, 0);
      wait_cyc(2776);
      check("R11", "refresh back in phase", refresh_req, 1);
      check("R5", "init_done held", init_done, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 2776);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule